// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is a data cache placed between a CPU load/store port and a word-wide backing-memory port. It has 128 sets of two ways each, 32-byte lines and 32-bit words. A store is always sent on to memory, and a store that misses never brings a line into the cache. Loads that hit are answered in the cycle they are presented. Loads that miss stall the CPU while the whole line is read from memory, and the requested word is returned after that.

The CPU holds a request (address, direction and write data) steady until the cache acknowledges it. The acknowledge returns read data for loads. While a request is pending and not yet acknowledged, the stall output is high. The memory side uses the same hold-until-acknowledge handshake, one word per transfer. Each set keeps one recency bit. That bit picks the way to refill when both ways are valid.

Top module: `wt2_dcache`

## Requirements
- R1: Reset clears every valid bit and every recency bit. The first load after reset to any address misses and reads a full line from memory.
- R2: Byte address bits [11:5] select the set and bits [31:12] form the tag. Lines that differ only in bits [11:5] live in separate sets and do not displace each other.
- R3: A load that hits raises the CPU acknowledge in the same cycle the request is presented. It returns the cached word and issues no memory request.
- R4: A load that misses issues 8 memory reads at the line base, with word offsets (address bits [4:2]) in ascending order 0 to 7. The acknowledge with the requested word comes one cycle after the eighth read is acknowledged.
- R5: Two lines with the same set and different tags can be resident together. After both are loaded, each one hits again.
- R6: On a miss, an invalid way is filled first. If both ways are valid, the way used less recently is replaced. Both hits and fills count as a use.
- R7: Every store makes exactly one memory write with the store's word address and data. The CPU acknowledge for the store comes in the cycle the memory acknowledges that write.
- R8: A store that hits also updates the cached word, so a later load of that word hits and returns the new data.
- R9: A store that misses allocates nothing. A load of the same address right after it misses and fills from memory, which then holds the stored data.
- R10: Address bits [1:0] are ignored. A load at any byte offset within a word returns the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request pending, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_stall | output | 1 | Request pending and not completed |
| mem_req | output | 1 | Memory transfer pending, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory transfer completed this cycle |

## Verification
A store that hits has two effects in the same cycle: the cached word is rewritten, and the write-through path to memory begins. A store hit to a resident line is followed by a load of that word. The load must hit with no memory read and return the new value, and the memory side must show one write with the same address and data. The second collision is between a line fill and recency tracking. The last fill beat installs the tag and marks that way as recently used. Alternating hits and misses on three tags in one set are checked against the number of memory reads each access costs.

// File: rtl/wt2_pkg.sv
package wt2_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILL  = 2'd1,
        S_WRITE = 2'd2,
        S_RESP  = 2'd3
    } wt2_state_e;

endpackage

// File: rtl/wt2_tag_array.sv
module wt2_tag_array #(
    parameter int SETS  = 128,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       hit,
    output logic             vic_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);

    // lru bit names the way to replace next
    typedef struct packed {
        logic [SETS-1:0][1:0] vld;
        logic [SETS-1:0]      lru;
    } meta_t;

    meta_t meta_d, meta_q;

    always_comb begin
        meta_d = meta_q;
        if (fill_en) begin
            meta_d.vld[fill_idx][fill_way] = 1'b1;
        end
        if (touch_en) begin
            meta_d.lru[touch_idx] = ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
        end else begin
            meta_q <= meta_d;
        end
    end

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == w[0])) begin
                tags[fill_idx] <= fill_tag;
            end
        end

        assign hit[w] = meta_q.vld[lk_idx][w] && (tags[lk_idx] == lk_tag);
    end

    always_comb begin
        if (!meta_q.vld[lk_idx][0]) begin
            vic_way = 1'b0;
        end else if (!meta_q.vld[lk_idx][1]) begin
            vic_way = 1'b1;
        end else begin
            vic_way = meta_q.lru[lk_idx];
        end
    end

    // R5
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/wt2_data_array.sv
module wt2_data_array #(
    parameter int SETS   = 128,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [WORD_W-1:0]       rd_word,
    output logic [1:0][DATA_W-1:0]  rd_data,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_way,
    input  logic [WORD_W-1:0]       wr_word,
    input  logic [DATA_W-1:0]       wr_data
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DATA_W-1:0] words [SETS*WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                words[{wr_idx, wr_word}] <= wr_data;
            end
        end

        assign rd_data[w] = words[{rd_idx, rd_word}];
    end

endmodule

// File: rtl/wt2_dcache.sv
module wt2_dcache
    import wt2_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int BYTE_W = $clog2(DATA_W/8);
    localparam int WORDS  = LINE_BYTES / (DATA_W/8);
    localparam int WORD_W = $clog2(WORDS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS-1);

    typedef struct packed {
        wt2_state_e        st;
        logic [WORD_W-1:0] cnt;
        logic              vic;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic [WORD_W-1:0] a_word;
    logic              byte_unused;

    assign a_idx       = cpu_addr[OFF_W +: IDX_W];
    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_word      = cpu_addr[BYTE_W +: WORD_W];
    assign byte_unused = ^cpu_addr[BYTE_W-1:0];

    logic [1:0]              hit;
    logic                    any_hit;
    logic                    vic_way;
    logic                    tfill_en;
    logic                    touch_en;
    logic                    touch_way;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic                    dwr_en;
    logic                    dwr_way;
    logic [WORD_W-1:0]       dwr_word;
    logic [DATA_W-1:0]       dwr_data;

    assign any_hit = |hit;

    wt2_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (a_idx),
        .lk_tag    (a_tag),
        .hit       (hit),
        .vic_way   (vic_way),
        .fill_en   (tfill_en),
        .fill_idx  (a_idx),
        .fill_way  (ctrl_q.vic),
        .fill_tag  (a_tag),
        .touch_en  (touch_en),
        .touch_idx (a_idx),
        .touch_way (touch_way)
    );

    wt2_data_array #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) i_data (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_word (a_word),
        .rd_data (rd_data),
        .wr_en   (dwr_en),
        .wr_idx  (a_idx),
        .wr_way  (dwr_way),
        .wr_word (dwr_word),
        .wr_data (dwr_data)
    );

    assign cpu_rdata = rd_data[hit[1]];
    assign cpu_stall = cpu_req && !cpu_ack;

    always_comb begin
        ctrl_d    = ctrl_q;
        cpu_ack   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = cpu_wdata;
        tfill_en  = 1'b0;
        touch_en  = 1'b0;
        touch_way = hit[1];
        dwr_en    = 1'b0;
        dwr_way   = hit[1];
        dwr_word  = a_word;
        dwr_data  = cpu_wdata;

        case (ctrl_q.st)
            S_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (any_hit) begin
                            dwr_en   = 1'b1;
                            touch_en = 1'b1;
                        end
                        ctrl_d.st = S_WRITE;
                    end else if (any_hit) begin
                        cpu_ack  = 1'b1;
                        touch_en = 1'b1;
                    end else begin
                        ctrl_d.st  = S_FILL;
                        ctrl_d.cnt = '0;
                        ctrl_d.vic = vic_way;
                    end
                end
            end
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    cpu_ack   = 1'b1;
                    ctrl_d.st = S_IDLE;
                end
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_addr[ADDR_W-1:OFF_W], ctrl_q.cnt, {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    dwr_en     = 1'b1;
                    dwr_way    = ctrl_q.vic;
                    dwr_word   = ctrl_q.cnt;
                    dwr_data   = mem_rdata;
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    if (ctrl_q.cnt == LAST_WORD) begin
                        tfill_en  = 1'b1;
                        touch_en  = 1'b1;
                        touch_way = ctrl_q.vic;
                        ctrl_d.st = S_RESP;
                    end
                end
            end
            S_RESP: begin
                cpu_ack   = 1'b1;
                ctrl_d.st = S_IDLE;
            end
            default: ctrl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: S_IDLE, cnt: '0, vic: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == S_IDLE && cpu_req && !cpu_we && any_hit) |-> (cpu_ack && !mem_req));

    // R4
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && (mem_addr[OFF_W-1:BYTE_W] != LAST_WORD))
        |=> (mem_req && !mem_we
             && (mem_addr[OFF_W-1:BYTE_W] == $past(mem_addr[OFF_W-1:BYTE_W]) + 1'b1)));

    // R4
    resp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == S_RESP) |-> any_hit);

    // R7
    store_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_we) |-> (mem_ack && mem_we));

endmodule

// File: tb/test_wt2_dcache.sv
`timescale 1ns/1ps
module test_wt2_dcache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack;
    logic        cpu_stall;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    wt2_dcache i_wt2_dcache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return {w[15:0] ^ 16'h5A5A, w[15:0]};
    endfunction

    // backing memory model, answers at negedge after one wait cycle
    logic [31:0] img [logic [31:0]];
    int          lat = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          seq_bad = 0;
    logic [31:0] last_rd = '0;
    logic [31:0] last_wa = '0;
    logic [31:0] last_wd = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat     <= 0;
        end else if (mem_req && !mem_ack) begin
            if (lat == 1) begin
                lat     <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    img[mem_addr] = mem_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    last_wa <= mem_addr;
                    last_wd <= mem_wdata;
                end else begin
                    mem_rdata <= img.exists(mem_addr) ? img[mem_addr] : pat(mem_addr);
                    if (mem_addr[4:0] != 5'd0 && mem_addr != last_rd + 32'd4)
                        seq_bad <= seq_bad + 1;
                    rd_cnt  <= rd_cnt + 1;
                    last_rd <= mem_addr;
                end
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    int          op_reads;
    int          op_writes;
    int          op_cycles;
    int          op_seq;
    logic [31:0] op_data;

    task automatic cpu_op(input logic we, input logic [31:0] addr, input logic [31:0] wd);
        int r0, w0, s0;
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt; s0 = seq_bad;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        op_cycles = 0;
        forever begin
            #1;
            if (cpu_ack) begin
                op_data = cpu_rdata;
                break;
            end
            @(negedge clk);
            op_cycles++;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        op_reads  = rd_cnt - r0;
        op_writes = wr_cnt - w0;
        op_seq    = seq_bad - s0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        use_pat;
        logic [31:0] exp;
        int          reads;
        int          writes;
    } vec_t;

    // set 3 holds tags 1 (A), 2 (B), 3 (C), 4 (D)
    localparam vec_t VECS [16] = '{
        '{1'b0, 32'h0000_1060, 32'h0, 1'b1, 32'h0,          8, 0}, // R1 cold miss A
        '{1'b0, 32'h0000_1060, 32'h0, 1'b1, 32'h0,          0, 0}, // R3 hit A
        '{1'b0, 32'h0000_2064, 32'h0, 1'b1, 32'h0,          8, 0}, // R4 miss B word 1
        '{1'b0, 32'h0000_1060, 32'h0, 1'b1, 32'h0,          0, 0}, // R5 A resident
        '{1'b0, 32'h0000_2064, 32'h0, 1'b1, 32'h0,          0, 0}, // R5 B resident
        '{1'b0, 32'h0000_3068, 32'h0, 1'b1, 32'h0,          8, 0}, // R6 C evicts A
        '{1'b0, 32'h0000_2064, 32'h0, 1'b1, 32'h0,          0, 0}, // R6 B kept
        '{1'b0, 32'h0000_1060, 32'h0, 1'b1, 32'h0,          8, 0}, // R6 A evicts C
        '{1'b0, 32'h0000_3068, 32'h0, 1'b1, 32'h0,          8, 0}, // R6 C evicts B
        '{1'b1, 32'h0000_1068, 32'hDEAD_0001, 1'b0, 32'h0,  0, 1}, // R7 store hit A
        '{1'b0, 32'h0000_1068, 32'h0, 1'b0, 32'hDEAD_0001,  0, 0}, // R8 updated word
        '{1'b1, 32'h0000_4070, 32'hCAFE_0002, 1'b0, 32'h0,  0, 1}, // R9 store miss D
        '{1'b0, 32'h0000_4070, 32'h0, 1'b0, 32'hCAFE_0002,  8, 0}, // R9 load misses
        '{1'b0, 32'h0000_106B, 32'h0, 1'b0, 32'hDEAD_0001,  0, 0}, // R10 byte offset
        '{1'b0, 32'h0000_10A0, 32'h0, 1'b1, 32'h0,          8, 0}, // R2 set 5 miss
        '{1'b0, 32'h0000_1064, 32'h0, 1'b1, 32'h0,          0, 0}  // R2 set 3 intact
    };

    function automatic string vec_req(input int i);
        case (i)
            0:             return "R1";
            1:             return "R3";
            2:             return "R4";
            3, 4:          return "R5";
            5, 6, 7, 8:    return "R6";
            9:             return "R7";
            10:            return "R8";
            11, 12:        return "R9";
            13:            return "R10";
            default:       return "R2";
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        check("R1", {31'd0, cpu_ack}, 32'd0);
        check("R1", {31'd0, mem_req}, 32'd0);

        for (int i = 0; i < 16; i++) begin
            vec_t v;
            logic [31:0] e;
            v = VECS[i];
            cpu_op(v.we, v.addr, v.wdata);
            check(vec_req(i), op_reads, v.reads);
            check(vec_req(i), op_writes, v.writes);
            if (!v.we) begin
                e = v.use_pat ? pat(v.addr) : v.exp;
                check(vec_req(i), op_data, e);
            end
            if (v.reads == 8) begin
                // R4 line base first, ascending, ending at offset 28
                check("R4", last_rd, {v.addr[31:5], 5'd0} + 32'd28);
                check("R4", op_seq, 0);
            end
            if (!v.we && v.reads == 0) begin
                // R3 answered in the request cycle
                check("R3", op_cycles, 0);
            end
            if (v.we) begin
                // R7 write carries the word address and data, and stalls
                check("R7", last_wa, {v.addr[31:2], 2'b00});
                check("R7", last_wd, v.wdata);
                check("R7", {31'd0, op_cycles > 0}, 32'd1);
            end
        end

        // R10 store at odd byte offset writes the word address
        cpu_op(1'b1, 32'h0000_1073, 32'h1234_5678);
        check("R10", last_wa, 32'h0000_1070);
        cpu_op(1'b0, 32'h0000_1070, 32'h0);
        check("R10", op_data, 32'h1234_5678);
        check("R10", op_reads, 0);

        // R1 reset in mid-run empties the cache
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_op(1'b0, 32'h0000_1070, 32'h0);
        check("R1", op_reads, 8);
        check("R1", op_data, 32'h1234_5678);
        cpu_op(1'b0, 32'h0000_2064, 32'h0);
        check("R1", op_reads, 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule